// File: doc/BRIEF.md
# Split-Nibble Pixel Stream Codec

This block carries 8-bit pixels across a 16-bit memory data path on which only the four lowest and four highest data lines are usable. On the write side, a pixel stream is packed into a byte stream. Each byte joins the upper nibble of one pixel with the lower nibble of the pixel before it. A line of N pixels therefore occupies N+1 bytes: one byte more than plain storage. The first byte carries only the first pixel's upper nibble, and the last byte carries only the last pixel's lower nibble.

On the read side, the packed bytes arrive one per transfer. The unpacker keeps a two-byte window that slides forward by a single byte each time. From every window after the opening byte of a line, it forms one 16-bit bus word. That word has the pixel's upper nibble on bits 15:12 and its lower nibble on bits 3:0, and every other bit is zero. Both directions use valid/ready handshakes and share one line-length input. Each side samples that input on the first item of a line.

Top module: `nibble_stream_codec`

## Requirements
- R1: For a line of N pixels (line length N, 1 to 255), the packer emits exactly N+1 bytes, and only the final byte has the packer's last flag set.
- R2: Packed byte 0 of a line is {first pixel bits 7:4, 4'h0}. Byte bits 7:4 are the upper nibble and bits 3:0 are the lower nibble.
- R3: Packed byte k, for 1 ≤ k ≤ N-1, is {pixel k bits 7:4, pixel k-1 bits 3:0}.
- R4: Packed byte N is {4'h0, pixel N-1 bits 3:0}.
- R5: The unpacker produces no word for the opening byte of a line. It produces exactly one word for each later byte, so a line of N+1 bytes yields N words and no extra word follows.
- R6: Word k of a line is formed from the window {byte k, byte k+1}, with the lower-address byte on bits 15:8. Its value is {byte k bits 7:4, 8'h00, byte k+1 bits 3:0}, which is {pixel k bits 7:4, 8'h00, pixel k bits 3:0}.
- R7: Bits 11:4 of every valid unpacker word are zero, so the usable-line mask is 16'hF00F.
- R8: The unpacker's last flag is set on word N-1 of each line and on no other word.
- R9: While an output is valid and not accepted, it stays valid and its data and last flag do not change. Under any back-pressure, no nibble is lost or duplicated.
- R10: After reset, both output valids are low and both input readies are high.
- R11: Each side samples the line length on the first item of a line. A change to the line length later in that line does not alter the line's byte or word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_len | input | LEN_W | Pixels per line, sampled on each side's first item of a line |
| pk_in_valid | input | 1 | Pixel offered to the packer |
| pk_in_ready | output | 1 | Packer accepts a pixel |
| pk_in_pix | input | 8 | Pixel value |
| pk_out_valid | output | 1 | Packed byte available |
| pk_out_ready | input | 1 | Downstream takes the packed byte |
| pk_out_byte | output | 8 | Packed byte |
| pk_out_last | output | 1 | Marks the closing byte of a line |
| up_in_valid | input | 1 | Packed byte offered to the unpacker |
| up_in_ready | output | 1 | Unpacker accepts a byte |
| up_in_byte | input | 8 | Packed byte value |
| up_out_valid | output | 1 | Bus word available |
| up_out_ready | input | 1 | Downstream takes the bus word |
| up_out_word | output | 16 | Reconstructed bus word, mask 16'hF00F |
| up_out_last | output | 1 | Marks the final pixel word of a line |

## Verification
The bench checks the one-pixel line, where the opening and closing bytes are adjacent. A packer that shares one counter test between them would merge or drop a byte there, and the unpacker would flag the wrong word as last. The bench also runs the longest line, which exposes a count that wraps or stops early. It applies heavy random back-pressure on both outputs, which catches a stage that overwrites a held byte or word and so loses or repeats a nibble. In one line it changes the line length partway through, which catches a design that re-reads the input instead of the sampled value and therefore ends the line at the wrong place.

// File: rtl/nibcodec_pkg.sv
package nibcodec_pkg;

  localparam logic [15:0] BUS_MASK = 16'hF00F;

  // Join two nibbles into one storage byte.
  function automatic logic [7:0] join_nibbles(input logic [3:0] upper, input logic [3:0] lower);
    return {upper, lower};
  endfunction

  // Bus word from a two-byte window; the earlier byte supplies bits 15:12.
  function automatic logic [15:0] window_word(input logic [7:0] early, input logic [7:0] late);
    return {early[7:4], 8'h00, late[3:0]};
  endfunction

endpackage

// File: rtl/nibcodec_packer.sv
module nibcodec_packer
  import nibcodec_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_last
);

  logic [LEN_W-1:0] pix_cnt;
  logic [LEN_W-1:0] len_q;
  logic [3:0]       carry_lo;
  logic             tail_pend;
  logic             ob_valid;
  logic [7:0]       ob_byte;
  logic             ob_last;

  // Named events for the assertions.
  logic             slot_free;
  logic             take_pix;
  logic             first_pix;
  logic             last_pix;
  logic             emit_tail;
  logic [LEN_W-1:0] cur_len;

  assign slot_free = !ob_valid || out_ready;
  assign in_ready  = slot_free && !tail_pend;
  assign take_pix  = in_valid && in_ready;
  assign first_pix = (pix_cnt == '0);
  assign cur_len   = first_pix ? line_len : len_q;
  assign last_pix  = take_pix && (pix_cnt == cur_len - LEN_W'(1));
  assign emit_tail = slot_free && tail_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_cnt   <= '0;
      len_q     <= '0;
      carry_lo  <= '0;
      tail_pend <= 1'b0;
      ob_valid  <= 1'b0;
      ob_byte   <= '0;
      ob_last   <= 1'b0;
    end else if (emit_tail) begin
      ob_valid  <= 1'b1;
      ob_byte   <= join_nibbles(4'h0, carry_lo);
      ob_last   <= 1'b1;
      tail_pend <= 1'b0;
    end else if (take_pix) begin
      ob_valid <= 1'b1;
      ob_byte  <= join_nibbles(in_pix[7:4], first_pix ? 4'h0 : carry_lo);
      ob_last  <= 1'b0;
      carry_lo <= in_pix[3:0];
      if (first_pix) len_q <= line_len;
      if (last_pix) begin
        pix_cnt   <= '0;
        tail_pend <= 1'b1;
      end else begin
        pix_cnt <= pix_cnt + LEN_W'(1);
      end
    end else if (out_ready) begin
      ob_valid <= 1'b0;
    end
  end

  assign out_valid = ob_valid;
  assign out_byte  = ob_byte;
  assign out_last  = ob_last;

  // R9: a stalled byte is held
  a_r9_pk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && !out_ready) |=> (ob_valid && $stable(ob_byte) && $stable(ob_last)));

  // R4: the closing byte carries no upper nibble
  a_r4_tail_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_last) |-> (ob_byte[7:4] == 4'h0));

  // R2: the opening byte carries no lower nibble
  a_r2_open_lower_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (take_pix && first_pix) |=> (ob_byte[3:0] == 4'h0 && !ob_last));

  // R1: two closing bytes never follow each other
  a_r1_single_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_last && out_ready) |=> !(ob_valid && ob_last));

endmodule

// File: rtl/nibcodec_unpacker.sv
module nibcodec_unpacker
  import nibcodec_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_byte,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_word,
  output logic             out_last
);

  logic [LEN_W-1:0] byte_cnt;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       early_byte;
  logic             ov;
  logic [15:0]      ow;
  logic             ol;

  logic             slot_free;
  logic             take;
  logic             opening;
  logic             closing;
  logic [LEN_W-1:0] cur_len;

  assign slot_free = !ov || out_ready;
  assign in_ready  = slot_free;
  assign take      = in_valid && in_ready;
  assign opening   = (byte_cnt == '0);
  assign cur_len   = opening ? line_len : len_q;
  assign closing   = take && !opening && (byte_cnt == cur_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_cnt   <= '0;
      len_q      <= '0;
      early_byte <= '0;
      ov         <= 1'b0;
      ow         <= '0;
      ol         <= 1'b0;
    end else begin
      if (take) early_byte <= in_byte;
      if (take && opening) begin
        len_q    <= line_len;
        byte_cnt <= LEN_W'(1);
      end
      if (take && !opening) begin
        ov       <= 1'b1;
        ow       <= window_word(early_byte, in_byte);
        ol       <= closing;
        byte_cnt <= closing ? '0 : byte_cnt + LEN_W'(1);
      end else if (out_ready) begin
        ov <= 1'b0;
      end
    end
  end

  assign out_valid = ov;
  assign out_word  = ow;
  assign out_last  = ol;

  // R7: unusable data lines stay low
  a_r7_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ov |-> ((ow & ~BUS_MASK) == 16'h0000));

  // R9: a stalled word is held
  a_r9_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !out_ready) |=> (ov && $stable(ow) && $stable(ol)));

  // R5: the opening byte yields no word
  a_r5_open_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (take && opening && (!ov || out_ready)) |=> !ov);

endmodule

// File: rtl/nibble_stream_codec.sv
module nibble_stream_codec #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] line_len,
  input  logic             pk_in_valid,
  output logic             pk_in_ready,
  input  logic [7:0]       pk_in_pix,
  output logic             pk_out_valid,
  input  logic             pk_out_ready,
  output logic [7:0]       pk_out_byte,
  output logic             pk_out_last,
  input  logic             up_in_valid,
  output logic             up_in_ready,
  input  logic [7:0]       up_in_byte,
  output logic             up_out_valid,
  input  logic             up_out_ready,
  output logic [15:0]      up_out_word,
  output logic             up_out_last
);

  nibcodec_packer #(.LEN_W(LEN_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_len  (line_len),
    .in_valid  (pk_in_valid),
    .in_ready  (pk_in_ready),
    .in_pix    (pk_in_pix),
    .out_valid (pk_out_valid),
    .out_ready (pk_out_ready),
    .out_byte  (pk_out_byte),
    .out_last  (pk_out_last)
  );

  nibcodec_unpacker #(.LEN_W(LEN_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_len  (line_len),
    .in_valid  (up_in_valid),
    .in_ready  (up_in_ready),
    .in_byte   (up_in_byte),
    .out_valid (up_out_valid),
    .out_ready (up_out_ready),
    .out_word  (up_out_word),
    .out_last  (up_out_last)
  );

endmodule

// File: tb/sim_nibble_stream_codec.sv
module sim_nibble_stream_codec;

  localparam int LEN_W = 8;

  logic             clk;
  logic             rst_n;
  logic [LEN_W-1:0] line_len;
  logic             pk_in_valid;
  logic             pk_in_ready;
  logic [7:0]       pk_in_pix;
  logic             pk_out_valid;
  logic             pk_out_ready;
  logic [7:0]       pk_out_byte;
  logic             pk_out_last;
  logic             up_in_valid;
  logic             up_in_ready;
  logic [7:0]       up_in_byte;
  logic             up_out_valid;
  logic             up_out_ready;
  logic [15:0]      up_out_word;
  logic             up_out_last;

  int checks = 0;
  int fails  = 0;
  logic [7:0] pix [0:299];
  logic [7:0] pbytes [0:300];
  logic first_pk, first_up;

  nibble_stream_codec #(.LEN_W(LEN_W)) u0 (.*);

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  // Expected packed byte k of an n-pixel line.
  function automatic logic [7:0] exp_byte(int k, int n);
    logic [3:0] hi, lo;
    hi = (k < n) ? pix[k][7:4] : 4'h0;
    lo = (k > 0) ? pix[k-1][3:0] : 4'h0;
    return {hi, lo};
  endfunction

  function automatic logic [15:0] exp_word(int k);
    return {pix[k][7:4], 8'h00, pix[k][3:0]};
  endfunction

  task automatic chk(input logic ok, input string req, input string ctx,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, ctx, act, expv);
    end
  endtask

  task automatic drive_pk(input int n);
    for (int i = 0; i < n; i++) begin
      while ($urandom % 3 == 0) begin @(negedge clk); pk_in_valid = 1'b0; end
      @(negedge clk);
      pk_in_valid = 1'b1;
      pk_in_pix   = pix[i];
      #5;
      while (!pk_in_ready) begin @(negedge clk); #5; end
      if (i == 0) first_pk = 1'b1;
    end
    @(negedge clk);
    pk_in_valid = 1'b0;
  endtask

  task automatic drive_up(input int n);
    for (int i = 0; i <= n; i++) begin
      while ($urandom % 3 == 0) begin @(negedge clk); up_in_valid = 1'b0; end
      @(negedge clk);
      up_in_valid = 1'b1;
      up_in_byte  = pbytes[i];
      #5;
      while (!up_in_ready) begin @(negedge clk); #5; end
      if (i == 0) first_up = 1'b1;
    end
    @(negedge clk);
    up_in_valid = 1'b0;
  endtask

  task automatic collect_pk(input int n, input bit heavy, input string ctx);
    int j = 0;
    bit stalled = 0;
    logic [7:0] held_b;
    logic held_l;
    while (j <= n) begin
      @(negedge clk);
      pk_out_ready = heavy ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      #5;
      if (stalled)
        chk(pk_out_valid && pk_out_byte == held_b && pk_out_last == held_l, "R9", ctx,
            {23'd0, pk_out_valid, pk_out_byte}, {24'd1, held_b});
      if (pk_out_valid && pk_out_ready) begin
        if (j == 0)      chk(pk_out_byte == pbytes[j], "R2", ctx, pk_out_byte, pbytes[j]);
        else if (j == n) chk(pk_out_byte == pbytes[j], "R4", ctx, pk_out_byte, pbytes[j]);
        else             chk(pk_out_byte == pbytes[j], "R3", ctx, pk_out_byte, pbytes[j]);
        chk(pk_out_last == (j == n), "R1", ctx, pk_out_last, (j == n));
        j++;
        stalled = 0;
      end else if (pk_out_valid) begin
        stalled = 1; held_b = pk_out_byte; held_l = pk_out_last;
      end else stalled = 0;
    end
    @(negedge clk);
    pk_out_ready = 1'b0;
  endtask

  task automatic collect_up(input int n, input bit heavy, input string ctx);
    int j = 0;
    bit stalled = 0;
    logic [15:0] held_w;
    logic held_l;
    while (j < n) begin
      @(negedge clk);
      up_out_ready = heavy ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      #5;
      if (stalled)
        chk(up_out_valid && up_out_word == held_w && up_out_last == held_l, "R9", ctx,
            {15'd0, up_out_valid, up_out_word}, {16'd1, held_w});
      if (up_out_valid && up_out_ready) begin
        chk(up_out_word == exp_word(j), "R6", ctx, up_out_word, exp_word(j));
        chk((up_out_word & 16'h0FF0) == 16'h0, "R7", ctx, up_out_word, 16'h0);
        chk(up_out_last == (j == n - 1), "R8", ctx, up_out_last, (j == n - 1));
        j++;
        stalled = 0;
      end else if (up_out_valid) begin
        stalled = 1; held_w = up_out_word; held_l = up_out_last;
      end else stalled = 0;
    end
    @(negedge clk);
    up_out_ready = 1'b0;
  endtask

  task automatic run_line(input int n, input bit heavy, input bit chg_len);
    string ctx;
    ctx = chg_len ? $sformatf("R11 len %0d", n) : $sformatf("len %0d", n);
    for (int i = 0; i < n; i++) pix[i] = 8'($urandom);
    for (int k = 0; k <= n; k++) pbytes[k] = exp_byte(k, n);
    @(negedge clk);
    line_len = LEN_W'(n);
    first_pk = 1'b0;
    first_up = 1'b0;
    fork
      drive_pk(n);
      drive_up(n);
      collect_pk(n, heavy, ctx);
      collect_up(n, heavy, ctx);
      begin
        if (chg_len) begin
          wait (first_pk && first_up);
          @(negedge clk);
          line_len = LEN_W'(n + 5);
        end
      end
    join
    // R1 / R5: nothing further is emitted for this line
    @(negedge clk);
    pk_out_ready = 1'b1;
    up_out_ready = 1'b1;
    repeat (3) begin
      @(negedge clk);
      #5;
      chk(!pk_out_valid, "R1", ctx, pk_out_valid, 0);
      chk(!up_out_valid, "R5", ctx, up_out_valid, 0);
    end
    @(negedge clk);
    pk_out_ready = 1'b0;
    up_out_ready = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    line_len = '0;
    pk_in_valid = 1'b0; pk_in_pix = '0; pk_out_ready = 1'b0;
    up_in_valid = 1'b0; up_in_byte = '0; up_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(!pk_out_valid, "R10", "reset", pk_out_valid, 0);
    chk(!up_out_valid, "R10", "reset", up_out_valid, 0);
    chk(pk_in_ready, "R10", "reset", pk_in_ready, 1);
    chk(up_in_ready, "R10", "reset", up_in_ready, 1);

    run_line(1, 1'b0, 1'b0);
    run_line(1, 1'b1, 1'b0);
    run_line(2, 1'b0, 1'b0);
    run_line(255, 1'b0, 1'b0);
    run_line(6, 1'b0, 1'b1);
    run_line(9, 1'b1, 1'b1);
    for (int t = 0; t < 24; t++)
      run_line(1 + int'($urandom % 16), bit'($urandom % 2), 1'b0);
    run_line(40, 1'b1, 1'b0);
    finish_run();
  end

endmodule